// File: doc/BRIEF.md
# Micro-Sequenced Multi-Cycle Processor Core

A small processor core that carries out every instruction as a chain of single-tick register transfers. A control unit holds a 2-bit step counter and a phase bit, fetch or execute. It also keeps its own copy of the 5-bit opcode. From these it decodes exactly one transfer per clock tick. The datapath has a program counter, an address register, a data register, an instruction field register, ALU operand registers L and R, an ALU result register A and eight general registers of `DATA_W` bits.

The core talks to an external synchronous RAM of 16-bit words. It drives an address, a write-mode line and write data, and it receives read data one tick after the address is presented. Each instruction takes four fetch ticks and four execute ticks. A boundary value is captured while reset is high, and no fetch or store above it is allowed. An undefined opcode or a refused access stops the core and raises a sticky flag.

Top module: `micro_cpu`

## Requirements
- R1: While reset is high and after its release, `halt`, `fault_bound`, `fault_illegal` and `mem_we` are 0 and `mem_addr` is 0. All general registers start at 0.
- R2: Every instruction takes exactly 8 ticks. Fetch tick 0 copies PC to the address register and increments PC in the same tick. Fetch tick 1 waits for the RAM. Fetch tick 2 loads the data register from `mem_rdata`. Fetch tick 3 moves it into the instruction register. Execute ticks 0 to 3 follow. Instructions run from consecutive addresses starting at 0.
- R3: The instruction word has opcode in bits [15:11], destination register in [10:8], source register in [7:5], a 5-bit signed immediate in [4:0], and the second source register in [2:0].
- R4: Opcode 1 (move) writes the source register's value into the destination register.
- R5: Opcode 2 (add immediate) writes source + sign-extended immediate, modulo 2^DATA_W, into the destination register.
- R6: Opcode 3 (register add) writes source + second source, modulo 2^DATA_W, into the destination register.
- R7: Opcode 4 (store) writes the destination register's value, zero-extended to 16 bits, to the RAM word addressed by the source register. `mem_we` is high for exactly one tick, the last execute tick.
- R8: Opcode 0 is a no-operation that changes no register and writes no memory.
- R9: Opcodes 5 to 31 set `fault_illegal` and `halt` at execute tick 0. The core then stays halted with no further memory writes.
- R10: A store whose address is above the boundary is refused: no write occurs, and `fault_bound` and `halt` are set at execute tick 1. An address equal to the boundary is legal.
- R11: A fetch from a PC above the boundary is refused at fetch tick 0. The address register keeps its old value, and `fault_bound` and `halt` are set.
- R12: `mem_we` is never high except during the last execute tick of a store whose address is within the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the boundary is captured while it is high |
| lim_addr | input | DATA_W | Highest legal address, sampled during reset |
| mem_addr | output | DATA_W | RAM address (address register) |
| mem_we | output | 1 | RAM write mode: 1 writes, 0 reads |
| mem_wdata | output | 16 | RAM write data (data register) |
| mem_rdata | input | 16 | RAM read data, valid one tick after the address |
| halt | output | 1 | Core stopped |
| fault_bound | output | 1 | Access above the boundary was refused |
| fault_illegal | output | 1 | Undefined opcode was met |

## Verification
The bench builds the core at its default `DATA_W` of 8, so the whole 256-word address space is modelled in the bench. This makes three things reachable. A program sweeps all 32 immediate values through the adder and stores each result. Stores near the top of the space exercise wrap-around addition. The boundary can be set both equal to and just below a real fetch or store address. Halt ticks are predicted from the 8-tick instruction length and compared at the exact tick.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int INSN_W  = 16;
  localparam int OP_W    = 5;
  localparam int SEL_W   = 3;
  localparam int IMM_W   = 5;
  localparam int FIELD_W = INSN_W - OP_W;

  localparam logic [OP_W-1:0] OP_NOP  = 5'd0;
  localparam logic [OP_W-1:0] OP_MOV  = 5'd1;
  localparam logic [OP_W-1:0] OP_ADDI = 5'd2;
  localparam logic [OP_W-1:0] OP_ADD  = 5'd3;
  localparam logic [OP_W-1:0] OP_ST   = 5'd4;

  // one register transfer per tick
  typedef enum logic [3:0] {
    XF_IDLE, XF_FETCH, XF_DR_MEM, XF_IR_DR, XF_L_SRC, XF_R_ZERO,
    XF_R_IMM, XF_R_REG, XF_A_ALU, XF_DST_A, XF_AR_L, XF_DR_REG, XF_ILLEGAL
  } xfer_e;
endpackage

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl import mcpu_pkg::*; (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt,
  input  logic [OP_W-1:0] op_in,
  output xfer_e           xf
);
  logic [1:0]      step;
  logic            in_exec;
  logic [OP_W-1:0] cu_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= 2'd0;
      in_exec <= 1'b0;
      cu_op   <= OP_NOP;
    end else if (!halt) begin
      step <= (step == 2'd3) ? 2'd0 : step + 2'd1;
      if (step == 2'd3) in_exec <= !in_exec;
      if (!in_exec && step == 2'd3) cu_op <= op_in;
    end
  end

  always_comb begin
    xf = XF_IDLE;
    if (halt) begin
      xf = XF_IDLE;
    end else if (!in_exec) begin
      case (step)
        2'd0:    xf = XF_FETCH;
        2'd1:    xf = XF_IDLE;
        2'd2:    xf = XF_DR_MEM;
        default: xf = XF_IR_DR;
      endcase
    end else begin
      case (cu_op)
        OP_NOP: xf = XF_IDLE;
        OP_MOV, OP_ADDI, OP_ADD: begin
          case (step)
            2'd0: xf = XF_L_SRC;
            2'd1: xf = (cu_op == OP_MOV)  ? XF_R_ZERO :
                       (cu_op == OP_ADDI) ? XF_R_IMM  : XF_R_REG;
            2'd2: xf = XF_A_ALU;
            default: xf = XF_DST_A;
          endcase
        end
        OP_ST: begin
          case (step)
            2'd0:    xf = XF_L_SRC;
            2'd1:    xf = XF_AR_L;
            2'd2:    xf = XF_DR_REG;
            default: xf = XF_IDLE;
          endcase
        end
        default: xf = (step == 2'd0) ? XF_ILLEGAL : XF_IDLE;
      endcase
    end
  end

  // R9
  step_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(step) && $stable(in_exec)));
endmodule

// File: rtl/mcpu_regs.sv
module mcpu_regs #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  ra_sel,
  input  logic [SEL_W-1:0]  rb_sel,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 2 ** SEL_W;
  logic [DATA_W-1:0] gpr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)                                     gpr[g] <= '0;
      else if (wr_en && wr_sel == SEL_W'(g))       gpr[g] <= wr_data;
    end
  end

  assign ra_data = gpr[ra_sel];
  assign rb_data = gpr[rb_sel];
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opl,
  input  logic [DATA_W-1:0] opr,
  output logic [DATA_W-1:0] sum
);
  assign sum = opl + opr;
endmodule

// File: rtl/micro_cpu.sv
module micro_cpu import mcpu_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] lim_addr,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [INSN_W-1:0] mem_wdata,
  input  logic [INSN_W-1:0] mem_rdata,
  output logic              halt,
  output logic              fault_bound,
  output logic              fault_illegal
);
  localparam int ADDR_W = DATA_W;

  xfer_e              xf;
  logic [ADDR_W-1:0]  pc, ar, bound_q;
  logic [INSN_W-1:0]  dr;
  logic [FIELD_W-1:0] ir_f;
  logic [DATA_W-1:0]  l_q, r_q, a_q, alu_y, rf_a, rf_b;
  logic [SEL_W-1:0]   f_dst, f_src, f_src2, rb_sel;
  logic [IMM_W-1:0]   f_imm;

  assign f_dst  = ir_f[8 +: SEL_W];
  assign f_src  = ir_f[5 +: SEL_W];
  assign f_imm  = ir_f[IMM_W-1:0];
  assign f_src2 = ir_f[SEL_W-1:0];
  assign rb_sel = (xf == XF_DR_REG) ? f_dst : f_src2;

  mcpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .halt(halt), .op_in(dr[INSN_W-1 -: OP_W]), .xf(xf)
  );

  mcpu_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .ra_sel(f_src), .rb_sel(rb_sel),
    .wr_en(xf == XF_DST_A), .wr_sel(f_dst), .wr_data(a_q),
    .ra_data(rf_a), .rb_data(rf_b)
  );

  mcpu_alu #(.DATA_W(DATA_W)) u_alu (.opl(l_q), .opr(r_q), .sum(alu_y));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; ar <= '0; dr <= '0; ir_f <= '0;
      l_q <= '0; r_q <= '0; a_q <= '0;
      mem_we <= 1'b0; halt <= 1'b0;
      fault_bound <= 1'b0; fault_illegal <= 1'b0;
      bound_q <= lim_addr;
    end else begin
      mem_we <= 1'b0;
      case (xf)
        XF_FETCH: begin
          if (pc > bound_q) begin
            fault_bound <= 1'b1;
            halt        <= 1'b1;
          end else begin
            ar <= pc;
            pc <= pc + 1'b1;
          end
        end
        XF_DR_MEM: dr   <= mem_rdata;
        XF_IR_DR:  ir_f <= dr[FIELD_W-1:0];
        XF_L_SRC:  l_q  <= rf_a;
        XF_R_ZERO: r_q  <= '0;
        XF_R_IMM:  r_q  <= {{(DATA_W-IMM_W){f_imm[IMM_W-1]}}, f_imm};
        XF_R_REG:  r_q  <= rf_b;
        XF_A_ALU:  a_q  <= alu_y;
        XF_AR_L: begin
          if (l_q > bound_q) begin
            fault_bound <= 1'b1;
            halt        <= 1'b1;
          end else begin
            ar <= l_q;
          end
        end
        XF_DR_REG: begin
          dr     <= INSN_W'(rf_b);
          mem_we <= 1'b1;
        end
        XF_ILLEGAL: begin
          fault_illegal <= 1'b1;
          halt          <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = ar;
  assign mem_wdata = dr;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc != $past(pc)) |-> (pc == $past(pc) + 1'b1));
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && !mem_we));
  // R10
  we_in_bound_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr <= bound_q));
  // R7
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  // R12
  we_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($past(xf) == XF_DR_REG));
endmodule

// File: tb/test_micro_cpu.sv
module test_micro_cpu;
  localparam int CLK_P = 10;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] lim_addr = '0;
  logic [DW-1:0] mem_addr;
  logic          mem_we;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata;
  logic          halt, fault_bound, fault_illegal;

  logic [15:0] ram [256];
  logic [15:0] img [256];
  logic        ld_we = 1'b0, ld_clr = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;
  int          wr_cnt;
  int          checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  micro_cpu #(.DATA_W(DW)) i_micro_cpu (
    .clk(clk), .rst(rst), .lim_addr(lim_addr), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halt(halt), .fault_bound(fault_bound), .fault_illegal(fault_illegal)
  );

  always @(posedge clk) begin
    if (ld_we) ram[ld_a] <= ld_d;
    else if (mem_we) ram[mem_addr] <= mem_wdata;
    if (ld_clr) wr_cnt <= 0;
    else if (mem_we && !ld_we) wr_cnt <= wr_cnt + 1;
    mem_rdata <= ram[mem_addr];
  end

  function automatic logic [15:0] enc(input int op, input int d, input int s, input int imm);
    return {op[4:0], d[2:0], s[2:0], imm[4:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_run(input logic [7:0] bnd);
    @(negedge clk);
    rst = 1'b1; lim_addr = bnd; ld_clr = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_a = i[7:0]; ld_d = img[i];
    end
    @(negedge clk);
    ld_we = 1'b0; ld_clr = 1'b0;
    // R1 reset state
    chk("R1 halt", {31'd0, halt}, 0);
    chk("R1 faults", {30'd0, fault_bound, fault_illegal}, 0);
    chk("R1 mem_we", {31'd0, mem_we}, 0);
    chk("R1 mem_addr", {24'd0, mem_addr}, 0);
    rst = 1'b0;
  endtask

  task automatic clear_img;
    for (int i = 0; i < 256; i++) img[i] = 16'hBEEF;
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    // ---------- run A: arithmetic sweep ----------
    clear_img();
    n = 0;
    img[n++] = enc(2, 3, 0, 5);        // r3 = 5
    img[n++] = enc(2, 7, 0, -8);       // r7 = 248
    img[n++] = enc(4, 0, 7, 0);        // [248] = r0
    img[n++] = enc(2, 7, 7, -1);
    for (int k = 0; k < 32; k++) begin
      img[n++] = enc(2, 1, 3, k - 16); // r1 = 5 + imm
      img[n++] = enc(4, 1, 7, 0);
      img[n++] = enc(2, 7, 7, -1);
    end
    img[n++] = enc(3, 4, 3, 1);        // r4 = r3 + r1 = 25
    img[n++] = enc(4, 4, 7, 0);
    img[n++] = enc(2, 7, 7, -1);
    img[n++] = enc(3, 4, 4, 4);        // r4 = 50
    img[n++] = enc(4, 4, 7, 0);
    img[n++] = enc(2, 7, 7, -1);
    img[n++] = enc(1, 5, 1, 0);        // r5 = r1 = 20
    img[n++] = enc(4, 5, 7, 0);
    img[n++] = enc(2, 7, 7, -1);
    img[n++] = enc(0, 5, 5, 7);        // no-op
    img[n++] = enc(4, 5, 7, 0);
    img[n++] = enc(31, 0, 0, 0);       // index 111: undefined
    start_run(8'd255);
    repeat (8 * 111 + 4) @(posedge clk);
    #1 chk("R9 R2 halt before illegal tick", {31'd0, halt}, 0);
    @(posedge clk);
    #1 chk("R9 R2 halt at illegal tick", {31'd0, halt}, 1);
    chk("R9 fault_illegal", {31'd0, fault_illegal}, 1);
    chk("R9 fault_bound clear", {31'd0, fault_bound}, 0);
    repeat (20) @(posedge clk);
    #1 chk("R1 registers start at zero", {16'd0, ram[248]}, 0);
    for (int k = 0; k < 32; k++) begin
      logic [7:0] e;
      e = 8'(5 + k - 16);
      chk("R5 R3 add immediate sweep", {16'd0, ram[247 - k]}, {24'd0, e});
    end
    chk("R6 register add", {16'd0, ram[215]}, 25);
    chk("R6 register add self", {16'd0, ram[214]}, 50);
    chk("R4 move", {16'd0, ram[213]}, 20);
    chk("R8 no-op leaves r5", {16'd0, ram[212]}, 20);
    chk("R8 R12 write count", wr_cnt, 37);
    chk("R12 untouched word", {16'd0, ram[211]}, 32'hBEEF);

    // ---------- run B: store above boundary ----------
    clear_img();
    img[0] = enc(2, 7, 0, -8);
    img[1] = enc(4, 3, 7, 0);
    start_run(8'd20);
    repeat (13) @(posedge clk);
    #1 chk("R10 no halt before check", {31'd0, halt}, 0);
    @(posedge clk);
    #1 chk("R10 halt on store fault", {31'd0, halt}, 1);
    chk("R10 fault_bound", {31'd0, fault_bound}, 1);
    chk("R10 fault_illegal clear", {31'd0, fault_illegal}, 0);
    repeat (20) @(posedge clk);
    #1 chk("R10 write refused", wr_cnt, 0);
    chk("R10 word kept", {16'd0, ram[248]}, 32'hBEEF);

    // ---------- run C: store at boundary, fetch past it ----------
    clear_img();
    img[0] = enc(2, 7, 0, 10);
    img[1] = enc(2, 7, 7, 10);         // r7 = 20
    img[2] = enc(4, 7, 7, 0);          // [20] = 20
    for (int i = 3; i <= 20; i++) img[i] = 16'h0000;
    start_run(8'd20);
    repeat (8 * 21) @(posedge clk);
    #1 chk("R11 no halt before fetch", {31'd0, halt}, 0);
    @(posedge clk);
    #1 chk("R11 halt on fetch fault", {31'd0, halt}, 1);
    chk("R11 fault_bound", {31'd0, fault_bound}, 1);
    chk("R11 address register kept", {24'd0, mem_addr}, 20);
    chk("R10 store at boundary", {16'd0, ram[20]}, 20);
    chk("R7 single write", wr_cnt, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule